// File: doc/BRIEF.md
# Monochrome LCD Refresh Controller

This block keeps a fixed 128 x 128 one-bit-per-pixel LCD panel refreshed from a frame buffer in system memory, with no help from the CPU. It acts as its own master on a shared 32-bit internal bus. It requests the bus, and once granted it reads a burst of two consecutive frame-buffer words into a three-entry word queue. A free-running pixel divider pulls words from that queue and sends each one to the column driver as eight 4-bit groups, most significant group first.

Around the pixel stream the block generates all the panel driver timing. This includes a pixel shift clock, a one-cycle row latch pulse with a matching row clock after every 32 groups (one 128-pixel row), a scan start pulse on the boundary into row 0, and a polarity signal that flips once per frame for AC drive. The frame buffer is 512 words read in address order. The word address is a fixed high part with a 9-bit counter in the low bits, and it wraps to word 0 at the end of every frame without a pause.

Top module: `lcd_refresh_engine`

## Requirements
- R1: While `rst_n` is low, `bus_req_n` and `rd_n` are 1, and `px_data`, `px_clk`, `row_latch`, `row_clk`, `scan_start`, `frame_pol` and `underflow` are all 0.
- R2: `bus_req_n` goes low only when at most one word is queued. `rd_n` goes low only after `bus_gnt_n` was seen low. Each request completes exactly two reads, one per low cycle of `ack_n`, and then `bus_req_n` and `rd_n` return high.
- R3: `addr_w` (word address, byte address bits 31:2) carries the fixed base in bits 29:9 and a word counter in bits 8:0. The counter starts at 0 after reset, steps by one on every acknowledged read, and wraps from 511 to 0.
- R4: Pixel group n of a frame (n = 0..4095) is bits [31-4k -: 4] of frame word n/8, with k = n mod 8. It is valid on `px_data` whenever `px_clk` is high. There is one `px_clk` pulse per group, at most one pulse every `DIV` clock cycles.
- R5: `row_latch` and `row_clk` pulse together for one cycle, once after every 32 groups have been clocked out, and at no other time.
- R6: `scan_start` pulses together with the row latch that follows group 4095 (the start of row 0). `frame_pol` toggles on exactly that cycle and at no other time.
- R7: With grant and acknowledge latencies of a few cycles, the group stream runs on across frame boundaries with no gap, and `underflow` stays 0.
- R8: If the queue and the shifter are both empty when a new group is due after streaming has begun, `underflow` is set and stays set until reset. No `px_clk` pulse is issued and `px_data` holds its last value until data arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req_n | output | 1 | Bus request, active low |
| bus_gnt_n | input | 1 | Bus grant, active low |
| rd_n | output | 1 | Read strobe, active low |
| ack_n | input | 1 | Per-word read acknowledge, active low |
| rdata | input | 32 | Read data, valid when `ack_n` is low |
| addr_w | output | 30 | Word address (byte address bits 31:2) |
| px_data | output | 4 | Column driver pixel group |
| px_clk | output | 1 | Column driver shift clock |
| row_latch | output | 1 | Row latch pulse |
| row_clk | output | 1 | Row driver shift clock |
| scan_start | output | 1 | Row scan start pulse |
| frame_pol | output | 1 | Frame polarity, toggles per frame |
| underflow | output | 1 | Sticky starvation flag |

## Verification
Most wrong internal state shows up at the pixel pins within one group period. A queue pointer that slips, a word address that skips, or a shifter that loads or shifts wrongly puts a group on `px_data` that differs from the reference frame word at the very next `px_clk` rise. A wrong row or frame position counter cannot be seen that quickly. It shows only at the next row boundary, up to 32 group periods later, as a latch pulse on the wrong group count, or at the end of the frame as a misplaced scan start or polarity flip. That is why the run lasts more than two full frames. A handshake fault shows up at the next burst as a read without a grant or a wrong acknowledge count.

// File: rtl/lcd_refresh_engine.sv
module lcd_refresh_engine #(
  parameter int          ROWS      = 128,
  parameter int          COLS      = 128,
  parameter int          DIV       = 4,
  parameter int          FDEPTH    = 3,
  parameter int          BURST     = 2,
  parameter logic [29:0] BASE_WORD = 30'h2A5C3E00
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        bus_req_n,
  input  logic        bus_gnt_n,
  output logic        rd_n,
  input  logic        ack_n,
  input  logic [31:0] rdata,
  output logic [29:0] addr_w,
  output logic [3:0]  px_data,
  output logic        px_clk,
  output logic        row_latch,
  output logic        row_clk,
  output logic        scan_start,
  output logic        frame_pol,
  output logic        underflow
);
  localparam int WORDS = ROWS * COLS / 32;
  localparam int AW    = $clog2(WORDS);
  localparam int PW    = $clog2(ROWS * COLS / 4);
  localparam int CPW   = $clog2(COLS / 4);
  localparam int DW    = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int FPW   = (FDEPTH > 1) ? $clog2(FDEPTH) : 1;
  localparam int FCW   = $clog2(FDEPTH + 1);
  localparam int BW    = (BURST > 1) ? $clog2(BURST) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_READ} bus_st_t;

  bus_st_t        state;
  logic [BW-1:0]  beat;
  logic [AW-1:0]  waddr;
  logic [31:0]    fifo [FDEPTH];
  logic [FPW-1:0] wp, rp;
  logic [FCW-1:0] fcnt;
  logic [DW-1:0]  div_cnt;
  logic [31:0]    sh;
  logic [2:0]     nib_left;
  logic [PW-1:0]  pos;
  logic           started, shown, row_end;

  wire tick    = (div_cnt == DW'(DIV - 1));
  wire have_sh = (nib_left != 3'd0);
  wire push    = (state == ST_READ) && !ack_n;
  wire pop     = tick && !have_sh && (fcnt != '0);
  wire emit    = tick && (have_sh || fcnt != '0);

  assign bus_req_n = (state == ST_IDLE);
  assign rd_n      = (state != ST_READ);
  assign addr_w    = {BASE_WORD[29:AW], waddr};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      beat  <= '0;
      waddr <= '0;
    end else begin
      case (state)
        ST_IDLE: if (fcnt <= FCW'(FDEPTH - BURST)) state <= ST_REQ;
        ST_REQ: begin
          beat <= '0;
          if (!bus_gnt_n) state <= ST_READ;
        end
        ST_READ: if (!ack_n) begin
          beat  <= beat + 1'b1;
          waddr <= waddr + 1'b1;
          if (beat == BW'(BURST - 1)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) fifo[wp] <= rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      fcnt <= '0;
    end else begin
      if (push) wp <= (wp == FPW'(FDEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == FPW'(FDEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   fcnt <= fcnt + 1'b1;
        2'b01:   fcnt <= fcnt - 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt    <= '0;
      sh         <= '0;
      nib_left   <= '0;
      pos        <= '0;
      started    <= 1'b0;
      shown      <= 1'b0;
      row_end    <= 1'b0;
      px_data    <= '0;
      px_clk     <= 1'b0;
      row_latch  <= 1'b0;
      row_clk    <= 1'b0;
      scan_start <= 1'b0;
      frame_pol  <= 1'b0;
      underflow  <= 1'b0;
    end else begin
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
      if (tick) begin
        if (have_sh) begin
          px_data  <= sh[31:28];
          sh       <= {sh[27:0], 4'h0};
          nib_left <= nib_left - 1'b1;
        end else if (fcnt != '0) begin
          px_data  <= fifo[rp][31:28];
          sh       <= {fifo[rp][27:0], 4'h0};
          nib_left <= 3'd7;
        end else if (started) begin
          underflow <= 1'b1;
        end
        if (emit) begin
          started <= 1'b1;
          pos     <= pos + 1'b1;
        end
        shown      <= emit;
        row_end    <= emit && (pos[CPW-1:0] == {CPW{1'b1}});
        row_latch  <= row_end;
        row_clk    <= row_end;
        scan_start <= row_end && (pos[PW-1:CPW] == '0);
        if (row_end && (pos[PW-1:CPW] == '0)) frame_pol <= ~frame_pol;
        px_clk     <= 1'b0;
      end else begin
        row_latch  <= 1'b0;
        row_clk    <= 1'b0;
        scan_start <= 1'b0;
        if (shown && div_cnt == DW'(DIV / 2 - 1)) px_clk <= 1'b1;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> (fcnt < FCW'(FDEPTH))); // R2
  AST_READ_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |-> $past(!bus_gnt_n)); // R2
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && !ack_n) |=> (addr_w[AW-1:0] == AW'($past(addr_w[AW-1:0]) + 1'b1))); // R3
  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (px_clk && $past(px_clk)) |-> $stable(px_data)); // R4
  AST_LATCH_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    row_latch |=> !row_latch); // R5
  AST_POL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scan_start) |-> !$stable(frame_pol)); // R6
  AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow); // R8
endmodule

// File: tb/test_lcd_refresh_engine.sv
module test_lcd_refresh_engine;
  localparam logic [29:0] BASE = 30'h2A5C3E00;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_req_n, bus_gnt_n, rd_n, ack_n;
  logic [31:0] rdata;
  logic [29:0] addr_w;
  logic [3:0]  px_data;
  logic        px_clk, row_latch, row_clk, scan_start, frame_pol, underflow;

  always #10 clk = ~clk;

  lcd_refresh_engine #(.BASE_WORD(BASE)) i_lcd_refresh_engine (
    .clk(clk), .rst_n(rst_n), .bus_req_n(bus_req_n), .bus_gnt_n(bus_gnt_n),
    .rd_n(rd_n), .ack_n(ack_n), .rdata(rdata), .addr_w(addr_w),
    .px_data(px_data), .px_clk(px_clk), .row_latch(row_latch), .row_clk(row_clk),
    .scan_start(scan_start), .frame_pol(frame_pol), .underflow(underflow));

  integer checks = 0, fails = 0;
  integer gnt_lat = 2, ack_lat = 1;
  integer nib_n = 0, sst_n = 0;
  logic [31:0] mem [512];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bus responder with its own address reference
  initial begin : bus_model
    integer gcnt, acnt, beats;
    logic [8:0] exp_addr;
    logic p_req;
    bus_gnt_n = 1'b1; ack_n = 1'b1; rdata = '0;
    gcnt = 0; acnt = 0; beats = 0; exp_addr = '0; p_req = 1'b1;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        bus_gnt_n = 1'b1; ack_n = 1'b1; gcnt = 0; acnt = 0; beats = 0;
        exp_addr = '0; p_req = 1'b1;
      end else begin
        if (bus_req_n && !p_req) begin
          chk(beats == 2, "R2 reads per burst", beats, 2);
          beats = 0;
        end
        p_req = bus_req_n;
        if (bus_req_n) begin
          bus_gnt_n = 1'b1; gcnt = 0;
        end else if (bus_gnt_n) begin
          gcnt++;
          if (gcnt >= gnt_lat) bus_gnt_n = 1'b0;
        end
        if (!ack_n) begin
          ack_n = 1'b1; acnt = 0;
        end else if (!rd_n) begin
          acnt++;
          if (acnt >= ack_lat) begin
            chk(!bus_gnt_n, "R2 read while granted", bus_gnt_n, 0);
            chk(addr_w == {BASE[29:9], exp_addr}, "R3 word address",
                addr_w, {BASE[29:9], exp_addr});
            ack_n = 1'b0;
            rdata = mem[addr_w[8:0]];
            exp_addr = exp_addr + 1'b1;
            beats++;
          end
        end
      end
    end
  end

  // behavioural reference of the driver stream, compared every clock
  initial begin : monitor
    logic p_clk, p_pol;
    logic [31:0] w;
    logic [3:0] exp;
    p_clk = 1'b0; p_pol = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        nib_n = 0; sst_n = 0; p_clk = 1'b0; p_pol = 1'b0;
      end else begin
        if (px_clk && !p_clk) begin
          w = mem[(nib_n / 8) % 512];
          exp = 4'(w >> (28 - 4 * (nib_n % 8)));
          chk(px_data == exp, "R4 pixel group", px_data, exp);
          nib_n++;
        end
        if (row_latch) begin
          chk(nib_n > 0 && nib_n % 32 == 0, "R5 latch position", nib_n % 32, 0);
          chk(row_clk, "R5 row clock with latch", row_clk, 1);
        end else if (row_clk) chk(0, "R5 row clock alone", 1, 0);
        if (scan_start) begin
          chk(nib_n % 4096 == 0 && row_latch, "R6 scan start position", nib_n, 4096);
          sst_n++;
        end
        if (frame_pol != p_pol) chk(scan_start, "R6 polarity flip", scan_start, 1);
        p_clk = px_clk; p_pol = frame_pol;
      end
    end
  end

  initial begin : watchdog
    repeat (120000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(bus_req_n && rd_n, "R1 bus idle in reset", {bus_req_n, rd_n}, 2'b11);
    chk({px_data, px_clk, row_latch, row_clk, scan_start, frame_pol, underflow} == '0,
        "R1 driver outputs in reset",
        {px_data, px_clk, row_latch, row_clk, scan_start, frame_pol, underflow}, 0);
    rst_n = 1'b1;
  endtask

  initial begin : main
    logic [3:0] held;
    integer n0;
    for (int i = 0; i < 512; i++) mem[i] = (i * 32'h9E3779B1) ^ (i << 20) ^ 32'h5A;
    // nominal latencies, two patterns, more than two frames (R7)
    gnt_lat = 2; ack_lat = 1;
    do_reset();
    repeat (4096 * 4 + 200) @(negedge clk);
    gnt_lat = 9; ack_lat = 3;
    repeat (4096 * 4 + 800) @(negedge clk);
    chk(nib_n > 8192, "R7 stream across frame wrap", nib_n, 8193);
    chk(sst_n == 2, "R7 scan starts in two frames", sst_n, 2);
    chk(!underflow, "R7 no underflow at nominal latency", underflow, 0);
    // starved bus: underflow (R8)
    gnt_lat = 400; ack_lat = 1;
    do_reset();
    for (int t = 0; t < 3000 && !underflow; t++) @(negedge clk);
    chk(underflow, "R8 underflow set when starved", underflow, 1);
    held = px_data; n0 = nib_n;
    repeat (20) @(negedge clk);
    chk(px_data == held, "R8 group held while starved", px_data, held);
    chk(nib_n == n0, "R8 no shift clock while starved", nib_n, n0);
    repeat (1500) @(negedge clk);
    chk(underflow, "R8 underflow sticky", underflow, 1);
    chk(nib_n > n0, "R8 stream resumes in order", nib_n, n0 + 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule